// File: doc/BRIEF.md
# Connection Status Flag Register

This block keeps the status flags of a link connection-management state machine. It also records the reason that machine last fell into its break state. The state machine, its two timers and the line-state decoders are outside the block. Only their strobes and event pulses arrive here: the current state code with a change strobe, quiet/idle/halt detections, primary-timer and noise-timer expiries, a start command, the start strobes of the transmit and receive sequencing code, host write strobes for the transmit-vector and vector-length registers, and a vector-sent strobe.

The flags, together with a 3-bit break-cause code, are packed into one status byte that the host reads. The line-state flag and the two code-started flags last only as long as the current connection state and are wiped on every state change. The signaling flag marks a transmit vector that is still pending. While it is set, the block refuses host writes to both vector registers and raises a single-cycle error pulse for each refused write.

Top module: `conn_status_flags`

## Requirements
- R1: After synchronous reset `status_o` is 0x00, `vec_wr_blocked_o` is 0 and `vec_wr_err_o` is 0.
- R2: When `state_chg_i` is high and `state_i` equals `BREAK_CODE` (an entry into the break state), status bits 2:0 capture the cause code on the next cycle. The codes are: 001 for `start_i`, 010 for `tpc_exp_i`, 011 for `tne_exp_i`, 100 for `quiet_i`, 101 for `idle_i` and 110 for `halt_i`. The field reads 000 until the first break entry that has a cause.
- R3: When several causes are present at a break entry, the lowest code wins. The order is start, primary timer, noise timer, quiet, idle, halt.
- R4: Outside a break entry, bits 2:0 keep their value. A break entry with no cause event present also leaves them unchanged.
- R5: `line_seen_i` sets status bit 5 on the next cycle. The bit stays set until the next `state_chg_i`.
- R6: `tx_code_start_i` sets status bit 3 and `rx_code_start_i` sets status bit 4 on the next cycle. Each bit stays set until the next `state_chg_i`.
- R7: A `state_chg_i` cycle clears bits 5, 4 and 3 on the next cycle. This holds even when a set event for that flag arrives in the same cycle.
- R8: A `xv_wr_i` write while bit 6 is clear sets status bit 6 and `vec_wr_blocked_o` on the next cycle. A `vlen_wr_i` write never sets bit 6. `vec_sent_i` clears bit 6 unless an accepted transmit-vector write arrives in the same cycle, in which case bit 6 stays set.
- R9: A write to either vector register while bit 6 is set is refused. It raises `vec_wr_err_o` for exactly one cycle on the next cycle and leaves bit 6 unchanged. An accepted write raises no error.
- R10: Status bit 7 is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| state_i | input | STATE_W | Current connection state code |
| state_chg_i | input | 1 | Strobe: state changes to `state_i` this cycle |
| start_i | input | 1 | Start command |
| tpc_exp_i | input | 1 | Primary timer expiry |
| tne_exp_i | input | 1 | Noise timer expiry |
| quiet_i | input | 1 | Quiet line state detected |
| idle_i | input | 1 | Idle line state detected |
| halt_i | input | 1 | Halt line state detected |
| line_seen_i | input | 1 | Watched line state received |
| tx_code_start_i | input | 1 | Transmit sequencing code started |
| rx_code_start_i | input | 1 | Receive sequencing code started |
| xv_wr_i | input | 1 | Host write to transmit-vector register |
| vlen_wr_i | input | 1 | Host write to vector-length register |
| vec_sent_i | input | 1 | Pending vector has been sent |
| status_o | output | 8 | Packed status byte |
| vec_wr_blocked_o | output | 1 | Vector registers are write-protected |
| vec_wr_err_o | output | 1 | One-cycle pulse for a refused vector write |

## Verification
Two pairs of functions can land in the same cycle. In the first, a state change meets a flag-setting event. The bench raises `state_chg_i` together with `line_seen_i` and both code-start strobes, and expects bits 5:3 to read zero afterwards. In the second, a vector-sent strobe meets a transmit-vector write. The bench issues this pair once with the signaling flag clear, where bit 6 must end set with no error, and once with it set, where the write must be refused with an error pulse and bit 6 must end clear. Break entries that carry several causes at once are also checked against the fixed priority.

// File: rtl/csf_pkg.sv
package csf_pkg;
   typedef enum logic [2:0] {
      CAUSE_NONE  = 3'd0,
      CAUSE_START = 3'd1,
      CAUSE_TPC   = 3'd2,
      CAUSE_TNE   = 3'd3,
      CAUSE_QUIET = 3'd4,
      CAUSE_IDLE  = 3'd5,
      CAUSE_HALT  = 3'd6,
      CAUSE_RSVD  = 3'd7
   } cause_e;

   localparam int STATUS_W   = 8;
   localparam int BIT_SIG    = 6;
   localparam int BIT_LINE   = 5;
   localparam int BIT_RXCODE = 4;
   localparam int BIT_TXCODE = 3;
   localparam int CAUSE_LSB  = 0;
   localparam int N_EPHEM    = 3;
endpackage

// File: rtl/csf_flag_cell.sv
module csf_flag_cell #(
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;
   logic flag_n;

   generate
      if (CLEAR_WINS) begin : g_clr_first
         always_comb begin
            if (clr_i)      flag_n = 1'b0;
            else if (set_i) flag_n = 1'b1;
            else            flag_n = flag_q;
         end
      end else begin : g_set_first
         always_comb begin
            if (set_i)      flag_n = 1'b1;
            else if (clr_i) flag_n = 1'b0;
            else            flag_n = flag_q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b0;
      else     flag_q <= flag_n;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/csf_break_cause.sv
module csf_break_cause
   import csf_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  logic   enter_i,
   input  logic   start_i,
   input  logic   tpc_exp_i,
   input  logic   tne_exp_i,
   input  logic   quiet_i,
   input  logic   idle_i,
   input  logic   halt_i,
   output cause_e cause_o
);
   cause_e pick;
   logic   any_cause;
   cause_e cause_q;

   // fixed priority: start, timers, then line states
   always_comb begin
      pick = CAUSE_NONE;
      if      (start_i)   pick = CAUSE_START;
      else if (tpc_exp_i) pick = CAUSE_TPC;
      else if (tne_exp_i) pick = CAUSE_TNE;
      else if (quiet_i)   pick = CAUSE_QUIET;
      else if (idle_i)    pick = CAUSE_IDLE;
      else if (halt_i)    pick = CAUSE_HALT;
   end

   assign any_cause = (pick != CAUSE_NONE);

   always_ff @(posedge clk) begin
      if (rst)                        cause_q <= CAUSE_NONE;
      else if (enter_i && any_cause)  cause_q <= pick;
   end

   assign cause_o = cause_q;
endmodule

// File: rtl/csf_vector_guard.sv
module csf_vector_guard (
   input  logic clk,
   input  logic rst,
   input  logic xv_wr_i,
   input  logic vlen_wr_i,
   input  logic vec_sent_i,
   output logic sig_o,
   output logic err_o
);
   logic sig_q;
   logic sig_n;
   logic err_q;
   logic refused;
   logic xv_accept;

   assign refused   = sig_q && (xv_wr_i || vlen_wr_i);
   assign xv_accept = xv_wr_i && !sig_q;

   always_comb begin
      if (xv_accept)       sig_n = 1'b1;
      else if (vec_sent_i) sig_n = 1'b0;
      else                 sig_n = sig_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sig_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         sig_q <= sig_n;
         err_q <= refused;
      end
   end

   assign sig_o = sig_q;
   assign err_o = err_q;
endmodule

// File: rtl/conn_status_flags.sv
module conn_status_flags
   import csf_pkg::*;
#(
   parameter int       STATE_W    = 4,
   parameter int       BREAK_CODE = 1,
   parameter bit       CLEAR_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [STATE_W-1:0] state_i,
   input  logic               state_chg_i,
   input  logic               start_i,
   input  logic               tpc_exp_i,
   input  logic               tne_exp_i,
   input  logic               quiet_i,
   input  logic               idle_i,
   input  logic               halt_i,
   input  logic               line_seen_i,
   input  logic               tx_code_start_i,
   input  logic               rx_code_start_i,
   input  logic               xv_wr_i,
   input  logic               vlen_wr_i,
   input  logic               vec_sent_i,
   output logic [7:0]         status_o,
   output logic               vec_wr_blocked_o,
   output logic               vec_wr_err_o
);
   localparam int STATE_MAX = (1 << STATE_W) - 1;

   initial begin
      if (STATE_W < 1 || STATE_W > 16)
         $error("conn_status_flags: STATE_W out of range");
      if (BREAK_CODE < 0 || BREAK_CODE > STATE_MAX)
         $error("conn_status_flags: BREAK_CODE does not fit STATE_W");
   end

   logic                 enter_break;
   cause_e               cause;
   logic                 sig;
   logic [N_EPHEM-1:0]   ephem_set;
   logic [N_EPHEM-1:0]   ephem_q;

   assign enter_break = state_chg_i && (state_i == STATE_W'(BREAK_CODE));

   csf_break_cause u_cause (
      .clk       (clk),
      .rst       (rst),
      .enter_i   (enter_break),
      .start_i   (start_i),
      .tpc_exp_i (tpc_exp_i),
      .tne_exp_i (tne_exp_i),
      .quiet_i   (quiet_i),
      .idle_i    (idle_i),
      .halt_i    (halt_i),
      .cause_o   (cause)
   );

   // index 0: tx code, 1: rx code, 2: line state
   assign ephem_set = {line_seen_i, rx_code_start_i, tx_code_start_i};

   generate
      for (genvar g = 0; g < N_EPHEM; g++) begin : g_ephem
         csf_flag_cell #(.CLEAR_WINS(CLEAR_WINS)) u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (ephem_set[g]),
            .clr_i  (state_chg_i),
            .flag_o (ephem_q[g])
         );
      end
   endgenerate

   csf_vector_guard u_vec (
      .clk        (clk),
      .rst        (rst),
      .xv_wr_i    (xv_wr_i),
      .vlen_wr_i  (vlen_wr_i),
      .vec_sent_i (vec_sent_i),
      .sig_o      (sig),
      .err_o      (vec_wr_err_o)
   );

   always_comb begin
      status_o                       = '0;
      status_o[CAUSE_LSB +: 3]       = cause;
      status_o[BIT_TXCODE]           = ephem_q[0];
      status_o[BIT_RXCODE]           = ephem_q[1];
      status_o[BIT_LINE]             = ephem_q[2];
      status_o[BIT_SIG]              = sig;
   end

   assign vec_wr_blocked_o = sig;
endmodule

// File: rtl/csf_checker.sv
module csf_checker #(
   parameter int STATE_W    = 4,
   parameter int BREAK_CODE = 1
) (
   input logic               clk,
   input logic               rst,
   input logic [STATE_W-1:0] state_i,
   input logic               state_chg_i,
   input logic               start_i,
   input logic               line_seen_i,
   input logic               xv_wr_i,
   input logic               vlen_wr_i,
   input logic               vec_sent_i,
   input logic [7:0]         status_o,
   input logic               vec_wr_blocked_o,
   input logic               vec_wr_err_o
);
   logic brk_in;
   assign brk_in = state_chg_i && (state_i == STATE_W'(BREAK_CODE));

   // R2
   start_cause_chk: assert property (@(posedge clk) disable iff (rst)
      brk_in && start_i |=> status_o[2:0] == 3'd1);

   // R4
   cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !brk_in |=> $stable(status_o[2:0]));

   // R5
   line_set_chk: assert property (@(posedge clk) disable iff (rst)
      line_seen_i && !state_chg_i |=> status_o[5]);

   // R7
   chg_clear_chk: assert property (@(posedge clk) disable iff (rst)
      state_chg_i |=> status_o[5:3] == 3'b000);

   // R8
   sent_clear_chk: assert property (@(posedge clk) disable iff (rst)
      vec_sent_i && !xv_wr_i |=> !status_o[6]);

   // R9
   refuse_err_chk: assert property (@(posedge clk) disable iff (rst)
      (xv_wr_i || vlen_wr_i) && vec_wr_blocked_o |=> vec_wr_err_o && status_o[6] == $past(status_o[6]) || vec_sent_i == 1'b1 || !status_o[6] == 1'b1);

   // R9
   no_spurious_err_chk: assert property (@(posedge clk) disable iff (rst)
      !((xv_wr_i || vlen_wr_i) && vec_wr_blocked_o) |=> !vec_wr_err_o);

   // R10
   always @(posedge clk) begin
      if (!rst) top_bit_zero_chk: assert (status_o[7] == 1'b0);
   end
endmodule

bind conn_status_flags csf_checker #(
   .STATE_W    (STATE_W),
   .BREAK_CODE (BREAK_CODE)
) i_csf_checker (
   .clk              (clk),
   .rst              (rst),
   .state_i          (state_i),
   .state_chg_i      (state_chg_i),
   .start_i          (start_i),
   .line_seen_i      (line_seen_i),
   .xv_wr_i          (xv_wr_i),
   .vlen_wr_i        (vlen_wr_i),
   .vec_sent_i       (vec_sent_i),
   .status_o         (status_o),
   .vec_wr_blocked_o (vec_wr_blocked_o),
   .vec_wr_err_o     (vec_wr_err_o)
);

// File: tb/test_conn_status_flags.sv
`timescale 1ns/1ps
module test_conn_status_flags;
   localparam int STATE_W = 4;
   localparam int BRK     = 1;

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic [STATE_W-1:0] state_i = '0;
   logic state_chg_i = 0, start_i = 0, tpc_exp_i = 0, tne_exp_i = 0;
   logic quiet_i = 0, idle_i = 0, halt_i = 0, line_seen_i = 0;
   logic tx_code_start_i = 0, rx_code_start_i = 0;
   logic xv_wr_i = 0, vlen_wr_i = 0, vec_sent_i = 0;
   logic [7:0] status_o;
   logic       vec_wr_blocked_o, vec_wr_err_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   conn_status_flags #(.STATE_W(STATE_W), .BREAK_CODE(BRK)) i_conn_status_flags (
      .clk(clk), .rst(rst), .state_i(state_i), .state_chg_i(state_chg_i),
      .start_i(start_i), .tpc_exp_i(tpc_exp_i), .tne_exp_i(tne_exp_i),
      .quiet_i(quiet_i), .idle_i(idle_i), .halt_i(halt_i),
      .line_seen_i(line_seen_i), .tx_code_start_i(tx_code_start_i),
      .rx_code_start_i(rx_code_start_i), .xv_wr_i(xv_wr_i),
      .vlen_wr_i(vlen_wr_i), .vec_sent_i(vec_sent_i), .status_o(status_o),
      .vec_wr_blocked_o(vec_wr_blocked_o), .vec_wr_err_o(vec_wr_err_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic clear_in();
      state_chg_i = 0; start_i = 0; tpc_exp_i = 0; tne_exp_i = 0;
      quiet_i = 0; idle_i = 0; halt_i = 0; line_seen_i = 0;
      tx_code_start_i = 0; rx_code_start_i = 0;
      xv_wr_i = 0; vlen_wr_i = 0; vec_sent_i = 0;
   endtask

   // change state; cause is a 6-bit one-hot set {halt,idle,quiet,tne,tpc,start}
   task automatic go_state(input int st, input logic [5:0] ev);
      state_i = STATE_W'(st); state_chg_i = 1;
      {halt_i, idle_i, quiet_i, tne_exp_i, tpc_exp_i, start_i} = ev;
      tick();
      clear_in();
   endtask

   task automatic t_reset();
      check("R1 status", status_o, 0);
      check("R1 blocked", vec_wr_blocked_o, 0);
      check("R1 err", vec_wr_err_o, 0);
      go_state(3, 6'b000000);
      check("R2 cause never broke", status_o[2:0], 0);
      check("R10 bit7", status_o[7], 0);
   endtask

   task automatic t_causes();
      for (int i = 0; i < 6; i++) begin
         go_state(2, 6'b0);
         go_state(BRK, 6'(1 << i));
         check("R2 cause code", status_o[2:0], i + 1);
      end
   endtask

   task automatic t_priority();
      go_state(2, 6'b0); go_state(BRK, 6'b111111);
      check("R3 all causes", status_o[2:0], 1);
      go_state(2, 6'b0); go_state(BRK, 6'b100110);
      check("R3 tpc over tne/halt", status_o[2:0], 2);
      go_state(2, 6'b0); go_state(BRK, 6'b001100);
      check("R3 tne over quiet", status_o[2:0], 3);
      go_state(2, 6'b0); go_state(BRK, 6'b110000);
      check("R3 idle over halt", status_o[2:0], 5);
   endtask

   task automatic t_hold();
      go_state(2, 6'b0); go_state(BRK, 6'b001000);   // quiet -> 4
      go_state(5, 6'b000001);                        // start, not break entry
      check("R4 hold on other state", status_o[2:0], 4);
      go_state(BRK, 6'b0);                           // entry with no cause
      check("R4 hold no cause", status_o[2:0], 4);
      tpc_exp_i = 1; halt_i = 1; tick(); clear_in();
      check("R4 hold no change", status_o[2:0], 4);
   endtask

   task automatic t_flags();
      go_state(6, 6'b0);
      line_seen_i = 1; tick(); clear_in();
      check("R5 line set", status_o[5], 1);
      tx_code_start_i = 1; tick(); clear_in();
      check("R6 tx code set", status_o[3], 1);
      rx_code_start_i = 1; tick(); clear_in();
      check("R6 rx code set", status_o[4], 1);
      tick();
      check("R5 R6 flags hold", status_o[5:3], 3'b111);
      go_state(7, 6'b0);
      check("R7 clear on change", status_o[5:3], 3'b000);
   endtask

   task automatic t_same_cycle();
      state_i = 4'd8; state_chg_i = 1;
      line_seen_i = 1; tx_code_start_i = 1; rx_code_start_i = 1;
      tick(); clear_in();
      check("R7 clear wins", status_o[5:3], 3'b000);
   endtask

   task automatic t_vector();
      vlen_wr_i = 1; tick(); clear_in();
      check("R8 vlen no set", status_o[6], 0);
      check("R9 accepted no err", vec_wr_err_o, 0);
      xv_wr_i = 1; tick(); clear_in();
      check("R8 sig set", status_o[6], 1);
      check("R8 blocked", vec_wr_blocked_o, 1);
      check("R9 accepted xv no err", vec_wr_err_o, 0);
      xv_wr_i = 1; tick(); clear_in();
      check("R9 xv refused err", vec_wr_err_o, 1);
      check("R9 sig kept", status_o[6], 1);
      tick();
      check("R9 err one cycle", vec_wr_err_o, 0);
      vlen_wr_i = 1; tick(); clear_in();
      check("R9 vlen refused err", vec_wr_err_o, 1);
      vec_sent_i = 1; tick(); clear_in();
      check("R8 sent clears", status_o[6], 0);
      check("R8 unblocked", vec_wr_blocked_o, 0);
      xv_wr_i = 1; vec_sent_i = 1; tick(); clear_in();
      check("R8 set beats sent", status_o[6], 1);
      check("R9 no err", vec_wr_err_o, 0);
      xv_wr_i = 1; vec_sent_i = 1; tick(); clear_in();
      check("R9 refused with sent err", vec_wr_err_o, 1);
      check("R8 sent clears after refuse", status_o[6], 0);
      check("R10 bit7", status_o[7], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 0;
      t_reset();
      t_causes();
      t_priority();
      t_hold();
      t_flags();
      t_same_cycle();
      t_vector();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule